// File: doc/BRIEF.md
# Prioritized interrupt vector dispatcher

This block carries out the vectored-interrupt dispatch step of a small 8-bit controller core. On a dispatch request it takes one snapshot of the interrupt sources and picks the highest-ranked active one. That choice becomes an even table offset in the range 0xE0 to 0xFE. The offset is spliced into the low byte of the 16-bit program counter, and the high byte is kept.

The block then reads the two-byte service-routine address from a synchronous program-memory read port at that location. It loads the result into the program counter and raises a one-cycle completion pulse.

There are fifteen ranked sources, in descending rank: a software trap, a latched non-maskable pending flag, and thirteen ordinary active lines. The first ordinary line is the external interrupt. The pending flag is set by a pulse input and cleared by a dedicated clear command or by reset.

Top module: `vec_dispatch`

## Requirements
- R1: After reset `busy`, `done` and `mem_rd` are 0, `pc_o` is 0x0000 and `nmi_pend` is 0.
- R2: Source rank 0 is the software trap (`trap_act`). When it is active at sampling, the offset is 0xFE, whatever else is active.
- R3: Source rank k maps to offset 0xFE − 2k. Rank 0 is the trap, rank 1 is `nmi_pend`, and rank k+2 is `irq_act[k]`. So `irq_act[0]` (external) gives 0xFA when the two higher ranks are idle, and `irq_act[12]` gives 0xE2.
- R4: When no source is active at sampling, the offset is 0xE0.
- R5: A request is accepted at a clock edge where `disp_req` is 1 and `busy` is 0. From the next cycle `pc_o` equals {`cur_pc[15:8]`, offset}, with the high byte taken from `cur_pc` at that edge.
- R6: `mem_rd` is 1 for exactly the two cycles after acceptance. `mem_addr` is {high byte, offset} in the first and {high byte, offset+1} in the second. Read data is taken one cycle after its address.
- R7: Three cycles after acceptance, `pc_o` becomes {byte at offset, byte at offset+1}. `done` is 1 for exactly that one cycle, and `busy` is 0 again.
- R8: Sources, `cur_pc` and `nmi_pend` are sampled only at the accepting edge. Later changes do not alter that dispatch.
- R9: `disp_req` has no effect while `busy` is 1 or `done` is 1.
- R10: A `nmi_set` pulse sets `nmi_pend` on the next edge, and `nmi_clr` clears it. When both are high, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_req | input | 1 | Dispatch request |
| cur_pc | input | 16 | Current program counter; high byte kept |
| trap_act | input | 1 | Software trap active (rank 0) |
| nmi_set | input | 1 | Sets the non-maskable pending flag |
| nmi_clr | input | 1 | Clear command for the pending flag |
| irq_act | input | 13 | Ordinary active lines, bit 0 is external |
| mem_rd | output | 1 | Program-memory read strobe |
| mem_addr | output | 16 | Program-memory read address |
| mem_rdata | input | 8 | Read data, valid one cycle after address |
| pc_o | output | 16 | Program counter result |
| busy | output | 1 | Dispatch in progress |
| done | output | 1 | One-cycle pulse, new PC valid |
| nmi_pend | output | 1 | Non-maskable pending flag |

## Verification
With acceptance at edge E0, the spliced PC and the first read address are due one edge later. The second address is due after E1, and the final PC with `done` after E3. `nmi_pend` follows its set and clear inputs one edge later.

The bench drives inputs and samples outputs on falling edges, so each check reads the value settled after exactly the edge counted. Right after acceptance it changes every source and `cur_pc` to show the snapshot holds. It keeps `disp_req` high across the busy cycles and then checks one more idle cycle, to show no second dispatch started.

// File: rtl/vec_dispatch.sv
module vec_dispatch #(
  parameter int NIRQ = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        disp_req,
  input  logic [15:0] cur_pc,
  input  logic        trap_act,
  input  logic        nmi_set,
  input  logic        nmi_clr,
  input  logic [12:0] irq_act,
  output logic        mem_rd,
  output logic [15:0] mem_addr,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] pc_o,
  output logic        busy,
  output logic        done,
  output logic        nmi_pend
);
  localparam int NLINE   = NIRQ + 2;
  localparam int TOP     = 254;
  localparam logic [7:0] DEFAULT_OFF = 8'hE0;

  typedef enum logic [1:0] {S_IDLE, S_RDHI, S_RDLO, S_LAST} st_t;
  st_t st;

  logic [NLINE-1:0] act;
  logic [7:0]       sel_off;
  logic [7:0]       vhi;
  logic             accept;

  assign act    = {irq_act[NIRQ-1:0], nmi_pend, trap_act};
  assign busy   = (st != S_IDLE);
  assign accept = disp_req && !busy && !done;
  assign mem_rd = (st == S_RDHI) || (st == S_RDLO);
  assign mem_addr = {pc_o[15:1], st == S_RDLO};

  always_comb begin
    sel_off = DEFAULT_OFF;
    for (int i = NLINE - 1; i >= 0; i--)
      if (act[i]) sel_off = 8'(TOP - 2 * i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) nmi_pend <= 1'b0;
    else if (nmi_clr) nmi_pend <= 1'b0;
    else if (nmi_set) nmi_pend <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      pc_o <= 16'h0000;
      vhi  <= 8'h00;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          pc_o <= {cur_pc[15:8], sel_off};
          st   <= S_RDHI;
        end
        S_RDHI: st <= S_RDLO;
        S_RDLO: begin
          vhi <= mem_rdata;
          st  <= S_LAST;
        end
        default: begin
          pc_o <= {vhi, mem_rdata};
          done <= 1'b1;
          st   <= S_IDLE;
        end
      endcase
    end
  end
endmodule

module vec_dispatch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        disp_req,
  input logic [15:0] cur_pc,
  input logic        nmi_clr,
  input logic        mem_rd,
  input logic [15:0] mem_addr,
  input logic [15:0] pc_o,
  input logic        busy,
  input logic        done,
  input logic        nmi_pend
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy && !mem_rd); // R7
  AST_RD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !$past(mem_rd)) |=> mem_rd && mem_addr == $past(mem_addr) + 16'd1); // R6
  AST_RD_END: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd)) |=> !mem_rd); // R6
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !$past(mem_rd)) |-> !mem_addr[0] && mem_addr[7:5] == 3'b111); // R3
  AST_HI_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done && disp_req) |=> busy && pc_o[15:8] == $past(cur_pc[15:8])); // R5
  AST_NMI_CLR: assert property (@(posedge clk) disable iff (!rst_n) nmi_clr |=> !nmi_pend); // R10
endmodule

bind vec_dispatch vec_dispatch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .disp_req(disp_req), .cur_pc(cur_pc), .nmi_clr(nmi_clr),
  .mem_rd(mem_rd), .mem_addr(mem_addr), .pc_o(pc_o), .busy(busy), .done(done),
  .nmi_pend(nmi_pend)
);

// File: tb/tb_vec_dispatch.sv
module tb_vec_dispatch;
  logic clk = 0, rst_n = 0, disp_req = 0, trap_act = 0, nmi_set = 0, nmi_clr = 0;
  logic [15:0] cur_pc = 16'h0000;
  logic [12:0] irq_act = '0;
  logic mem_rd, busy, done, nmi_pend;
  logic [15:0] mem_addr, pc_o;
  logic [7:0] mem_rdata = 8'h00;
  int checks = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;

  vec_dispatch dut (.*);

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return 8'((a[7:0] * 37) ^ a[15:8] ^ 8'h5A);
  endfunction

  always_ff @(posedge clk) if (mem_rd) mem_rdata <= mem_f(mem_addr);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [7:0] hi, input bit t, input bit n, input logic [12:0] irq, input string tag);
    logic [7:0] off;
    logic [15:0] exp_pc;
    int rk;
    rk = -1;
    if (n) begin
      @(negedge clk) nmi_set = 1;
      @(negedge clk) nmi_set = 0;
      chk(nmi_pend == 1, "R10 set", nmi_pend, 1);
    end
    for (int k = 12; k >= 0; k--) if (irq[k]) rk = k + 2;
    if (n) rk = 1;
    if (t) rk = 0;
    off = (rk < 0) ? 8'hE0 : 8'(254 - 2 * rk);
    exp_pc = {mem_f({hi, off}), mem_f({hi, off | 8'h01})};
    @(negedge clk);
    trap_act = t; irq_act = irq; cur_pc = {hi, 8'h3C}; disp_req = 1;
    @(negedge clk);
    chk(pc_o == {hi, off}, {tag, " R5 splice"}, pc_o, {hi, off});
    chk(mem_rd && mem_addr == {hi, off}, {tag, " R6 addr hi"}, mem_addr, {hi, off});
    trap_act = 1; irq_act = '1; cur_pc = ~cur_pc;
    @(negedge clk);
    chk(mem_rd && mem_addr == {hi, off | 8'h01}, {tag, " R6 addr lo R8"}, mem_addr, {hi, off | 8'h01});
    @(negedge clk);
    chk(!mem_rd && !done && busy, {tag, " R6 rd end"}, {mem_rd, done, busy}, 3'b001);
    @(negedge clk);
    chk(done && !busy && pc_o == exp_pc, {tag, " R7 R8 final"}, {done, pc_o}, {1'b1, exp_pc});
    disp_req = 0;
    @(negedge clk);
    chk(!done && !busy && !mem_rd && pc_o == exp_pc, {tag, " R9 ignored"}, {done, busy, pc_o}, {2'b00, exp_pc});
    trap_act = 0; irq_act = '0;
    if (n) begin
      nmi_clr = 1;
      @(negedge clk) nmi_clr = 0;
      chk(nmi_pend == 0, "R10 clear", nmi_pend, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_rd && pc_o == 0 && !nmi_pend, "R1 reset", {busy, done, mem_rd, nmi_pend, pc_o}, 0);
    rst_n = 1;
    run(8'h12, 0, 0, '0, "R4 none");
    run(8'hA5, 1, 1, '1, "R2 all");
    run(8'h00, 1, 0, '0, "R2 trap only");
    run(8'h7F, 0, 1, 13'h0001, "R3 nmi over ext");
    run(8'h40, 0, 0, 13'h0001, "R3 ext FA");
    for (int k = 0; k < 13; k++) begin
      run(8'(k * 19 + 3), 0, 0, 13'(1 << k), "R3 single");
      run(8'(k * 7 + 200), 0, 0, 13'('1 << k), "R3 ranked");
    end
    @(negedge clk) nmi_set = 1; nmi_clr = 1;
    @(negedge clk) nmi_set = 0; nmi_clr = 0;
    chk(nmi_pend == 0, "R10 clear wins", nmi_pend, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule